// File: doc/BRIEF.md
# Message Buffer DMA Read Handshake

This block sits between a bank of receive message buffers and an external DMA controller that shares the 8-bit processor data bus. It keeps a count of complete messages held in the buffers. While that count is non-zero and requests are enabled, it pulls an active-low request line low. Partially received messages never raise the request.

Once the controller answers by driving its acknowledge low, the block serves one byte per strobe. The strobe source depends on the strobe-mode input. With `dir_mode` = 0, each falling edge of `rd_n` advances the data. With `dir_mode` = 1, `rd_n` is a direction line, where high means read, and each falling edge of `wr_n` advances the data. The block releases the request as soon as the last byte of the last complete message has been popped.

All handshake inputs are brought onto the processor clock through a parameterised synchroniser, and all outputs are registered on that clock. Two further outputs exist. An active-low interrupt reports a message that completes while requests are disabled. A sticky flag records strobes that arrive when no data is available.

The controller has three states:
- `ST_IDLE`: no request is asserted.
- `ST_ARMED`: the request is asserted and the block is waiting for the acknowledge.
- `ST_XFER`: the acknowledge has been seen and strobes are served.

Its transitions are:
- IDLE→ARMED when the count is non-zero and requests are enabled.
- ARMED→XFER when the synchronised acknowledge is low.
- ARMED→IDLE when the count falls to zero or requests are disabled.
- XFER→ARMED when the acknowledge is released while messages remain and requests are enabled.
- XFER→IDLE when the acknowledge is released otherwise.

Top module: `mbdma_rd`

## Requirements
- R1: After reset, `dma_req_n`=1, `bus_oe`=0, `irq_n`=1, `err_underflow`=0 and `buf_pop`=0.
- R2: `dma_req_n` is low only while the complete-message count is non-zero and `req_en`=1. Bytes written without a `msg_done` pulse never lower it.
- R3: No byte is popped and `bus_oe` stays 0 until the synchronised `dma_ack_n` has been seen low after the request was raised. Strobes without acknowledge are ignored.
- R4: In read-strobe mode (`dir_mode`=0), each falling edge of `rd_n` in a transfer pops exactly one byte and places it on `bus_dout`. Edges of `wr_n` have no effect.
- R5: In direction mode (`dir_mode`=1), each falling edge of `wr_n` while `rd_n`=1 pops exactly one byte. `wr_n` edges while `rd_n`=0 are ignored, and so are edges of `rd_n`.
- R6: The count rises by one on a `msg_done` pulse and falls by one when a byte flagged `buf_last`=1 is popped. `dma_req_n` returns high once the count reaches zero.
- R7: `bus_oe` is 1 only while the synchronised acknowledge and the active strobe are both low, with `rd_n`=1 in direction mode. It returns to 0 once the strobe is released.
- R8: A strobe in a transfer with a count of zero pops nothing and sets `err_underflow`. The flag stays set until reset.
- R9: A `msg_done` pulse while `req_en`=0 drives `irq_n` low. A one-cycle pulse on `irq_clr` returns it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; all sampling and launching |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 1 | Enables the DMA request |
| dir_mode | input | 1 | 0: rd_n is the strobe; 1: rd_n is direction, wr_n is the strobe |
| msg_done | input | 1 | One-cycle pulse: a complete message entered the buffers |
| buf_data | input | DATA_W | Byte at the head of the buffers |
| buf_last | input | 1 | Head byte ends its message |
| buf_pop | output | 1 | Advances the buffers by one byte |
| dma_ack_n | input | 1 | Active-low acknowledge from the DMA controller |
| rd_n | input | 1 | Read strobe or direction line |
| wr_n | input | 1 | Write strobe (direction mode data strobe) |
| dma_req_n | output | 1 | Active-low DMA request |
| bus_dout | output | DATA_W | Data presented to the bus |
| bus_oe | output | 1 | Output enable for bus_dout |
| irq_n | output | 1 | Active-low interrupt |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| err_underflow | output | 1 | Sticky flag for a strobe with no data |

## Verification
The transfer path is driven three ways. The first is a three-byte message in read-strobe mode, drained byte by byte with one extra strobe after it. The second is two back-to-back messages in direction mode. The third is a message that completes while requests are disabled.

The read-strobe run separates correct per-edge popping from double popping, and it shows the request dropping exactly at the last byte. The extra strobe shows that underflow is caught. The direction-mode run separates the two strobe sources and shows write-direction strobes being rejected. Strobes sent before any acknowledge, and bytes sent without completion, show that neither partial data nor an unacknowledged strobe moves the buffers.

// File: rtl/mbdma_pkg.sv
package mbdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_XFER  = 2'd2
    } dma_st_e;
endpackage

// File: rtl/mbdma_sync.sv
// Brings one active-low handshake line onto the processor clock and
// flags its falling edge after synchronisation.
module mbdma_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic q,
    output logic fell
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= 1'b1;
                    else        pipe[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[i] <= 1'b1;
                    else        pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= pipe[STAGES-1];
    end

    assign q    = pipe[STAGES-1];
    assign fell = prev & ~pipe[STAGES-1];
endmodule

// File: rtl/mbdma_msgcnt.sv
// Count of complete messages waiting in the receive buffers.
module mbdma_msgcnt #(
    parameter int MAX_MSGS = 8,
    localparam int CNT_W   = $clog2(MAX_MSGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_MSGS);

    always_comb begin
        cnt_nxt = cnt;
        unique case ({inc, dec})
            2'b10:   if (cnt != CNT_MAX) cnt_nxt = cnt + 1'b1;
            2'b01:   if (cnt != '0)      cnt_nxt = cnt - 1'b1;
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    // R6: a completion with no final pop raises the count by one
    p_cnt_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

    // R6: a final-byte pop with no completion lowers the count by one
    p_cnt_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/mbdma_rd.sv
module mbdma_rd #(
    parameter int DATA_W    = 8,
    parameter int MAX_MSGS  = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic              dir_mode,
    input  logic              msg_done,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              buf_last,
    output logic              buf_pop,
    input  logic              dma_ack_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              dma_req_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              irq_n,
    input  logic              irq_clr,
    output logic              err_underflow
);
    import mbdma_pkg::*;

    localparam int CNT_W = $clog2(MAX_MSGS + 1);

    logic ack_q, ack_fell;
    logic rd_q, rd_fell;
    logic wr_q, wr_fell;

    mbdma_sync #(.STAGES(SYNC_STG)) u_ack (
        .clk(clk), .rst_n(rst_n), .din(dma_ack_n), .q(ack_q), .fell(ack_fell));
    mbdma_sync #(.STAGES(SYNC_STG)) u_rd (
        .clk(clk), .rst_n(rst_n), .din(rd_n), .q(rd_q), .fell(rd_fell));
    mbdma_sync #(.STAGES(SYNC_STG)) u_wr (
        .clk(clk), .rst_n(rst_n), .din(wr_n), .q(wr_q), .fell(wr_fell));

    logic [CNT_W-1:0] msg_cnt, cnt_nxt;
    logic             have_msg;

    dma_st_e state_q, state_d;

    logic strobe_fall, strobe_low, dir_ok, hit, underflow;

    // Strobe selection: rd_n directly, or wr_n gated by the rd_n direction line
    always_comb begin
        if (dir_mode) begin
            strobe_fall = wr_fell;
            strobe_low  = ~wr_q;
            dir_ok      = rd_q;
        end else begin
            strobe_fall = rd_fell;
            strobe_low  = ~rd_q;
            dir_ok      = 1'b1;
        end
    end

    assign have_msg  = (msg_cnt != '0);
    assign hit       = (state_q == ST_XFER) && strobe_fall && dir_ok;
    assign buf_pop   = hit && have_msg;
    assign underflow = hit && !have_msg;

    mbdma_msgcnt #(.MAX_MSGS(MAX_MSGS)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc(msg_done), .dec(buf_pop && buf_last),
        .cnt(msg_cnt), .cnt_nxt(cnt_nxt));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (have_msg && req_en) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!have_msg || !req_en) state_d = ST_IDLE;
                else if (!ack_q)          state_d = ST_XFER;
            end
            ST_XFER:  if (ack_q) state_d = (have_msg && req_en) ? ST_ARMED : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_req_n     <= 1'b1;
            bus_dout      <= '0;
            bus_oe        <= 1'b0;
            irq_n         <= 1'b1;
            err_underflow <= 1'b0;
        end else begin
            dma_req_n <= !(req_en && (cnt_nxt != '0));
            if (buf_pop) bus_dout <= buf_data;
            bus_oe <= (state_q == ST_XFER) && !ack_q && strobe_low && dir_ok;
            if (msg_done && !req_en) irq_n <= 1'b0;
            else if (irq_clr)        irq_n <= 1'b1;
            if (underflow) err_underflow <= 1'b1;
        end
    end

    // R2: the request is never asserted without a complete message
    p_req_needs_msg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req_n |-> (msg_cnt != '0));

    // R6: an empty buffer set always shows the request released
    p_empty_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_cnt == '0) |-> dma_req_n);

    // R4: one pop per strobe edge, never two in adjacent cycles
    p_one_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |=> !buf_pop);

    // R8: the underflow flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

    // R9: completion with requests disabled raises the interrupt
    p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_done && !req_en) |=> !irq_n);

    // R3: the transfer state is only reached through an acknowledge
    p_xfer_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_XFER) |-> $past(!ack_q));

    logic unused_ok;
    assign unused_ok = ack_fell;
endmodule

// File: tb/sim_mbdma_rd.sv
module sim_mbdma_rd;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_en = 1'b1, dir_mode = 1'b0, msg_done = 1'b0;
    logic [7:0] buf_data;
    logic       buf_last;
    logic       buf_pop;
    logic       dma_ack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic       dma_req_n;
    logic [7:0] bus_dout;
    logic       bus_oe, irq_n;
    logic       irq_clr = 1'b0;
    logic       err_underflow;

    int checks = 0;
    int errors = 0;
    int pops = 0;
    bit done = 1'b0;

    logic [7:0] mem [0:63];
    logic       lastf [0:63];
    int         wp = 0;
    int         rp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign buf_data = mem[rp[5:0]];
    assign buf_last = lastf[rp[5:0]];

    always @(posedge clk) if (buf_pop) rp <= rp + 1;
    always @(negedge clk) if (buf_pop) pops++;

    mbdma_rd u0 (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .dir_mode(dir_mode),
        .msg_done(msg_done), .buf_data(buf_data), .buf_last(buf_last),
        .buf_pop(buf_pop), .dma_ack_n(dma_ack_n), .rd_n(rd_n), .wr_n(wr_n),
        .dma_req_n(dma_req_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .irq_n(irq_n), .irq_clr(irq_clr), .err_underflow(err_underflow));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b, input logic lst);
        mem[wp[5:0]]   = b;
        lastf[wp[5:0]] = lst;
        wp++;
    endtask

    task automatic pulse_done();
        @(negedge clk) msg_done = 1'b1;
        @(negedge clk) msg_done = 1'b0;
        wait_clk(2);
    endtask

    task automatic strobe_rd();
        @(negedge clk) rd_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic release_rd();
        @(negedge clk) rd_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic strobe_wr();
        @(negedge clk) wr_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic release_wr();
        @(negedge clk) wr_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic set_ack(input logic v);
        @(negedge clk) dma_ack_n = v;
        wait_clk(4);
    endtask

    task automatic t_reset();
        chk(dma_req_n == 1'b1, "R1 req_n", dma_req_n, 1);
        chk(bus_oe == 1'b0, "R1 oe", bus_oe, 0);
        chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
        chk(err_underflow == 1'b0, "R1 err", err_underflow, 0);
        chk(buf_pop == 1'b0, "R1 pop", buf_pop, 0);
    endtask

    task automatic t_rd_mode();
        int p0;
        dir_mode = 1'b0;
        put_byte(8'hA1, 1'b0);
        put_byte(8'hA2, 1'b0);
        wait_clk(3);
        chk(dma_req_n == 1'b1, "R2 partial no req", dma_req_n, 1);
        put_byte(8'hA3, 1'b1);
        pulse_done();
        chk(dma_req_n == 1'b0, "R2 req on complete", dma_req_n, 0);
        p0 = pops;
        strobe_rd();
        chk(bus_oe == 1'b0, "R3 no oe before ack", bus_oe, 0);
        release_rd();
        chk(pops == p0, "R3 no pop before ack", pops - p0, 0);
        set_ack(1'b0);
        strobe_wr();
        release_wr();
        chk(pops == p0, "R4 wr ignored in rd mode", pops - p0, 0);
        strobe_rd();
        chk(bus_dout == 8'hA1, "R4 byte 1", bus_dout, 8'hA1);
        chk(bus_oe == 1'b1, "R7 oe during strobe", bus_oe, 1);
        release_rd();
        chk(bus_oe == 1'b0, "R7 oe after strobe", bus_oe, 0);
        strobe_rd();
        chk(bus_dout == 8'hA2, "R4 byte 2", bus_dout, 8'hA2);
        release_rd();
        chk(dma_req_n == 1'b0, "R6 req held mid message", dma_req_n, 0);
        strobe_rd();
        chk(bus_dout == 8'hA3, "R4 byte 3", bus_dout, 8'hA3);
        release_rd();
        chk(pops == p0 + 3, "R4 one pop per edge", pops - p0, 3);
        chk(dma_req_n == 1'b1, "R6 req released when empty", dma_req_n, 1);
        chk(err_underflow == 1'b0, "R8 no err yet", err_underflow, 0);
        strobe_rd();
        release_rd();
        chk(pops == p0 + 3, "R8 no pop on empty", pops - p0, 3);
        chk(err_underflow == 1'b1, "R8 err set", err_underflow, 1);
        set_ack(1'b1);
        wait_clk(4);
        chk(err_underflow == 1'b1, "R8 err sticky", err_underflow, 1);
    endtask

    task automatic t_dir_mode();
        int p0;
        dir_mode = 1'b1;
        @(negedge clk) rd_n = 1'b0;
        wait_clk(4);
        put_byte(8'hB1, 1'b0);
        put_byte(8'hB2, 1'b1);
        pulse_done();
        put_byte(8'hC1, 1'b0);
        put_byte(8'hC2, 1'b1);
        pulse_done();
        chk(dma_req_n == 1'b0, "R2 req two messages", dma_req_n, 0);
        p0 = pops;
        set_ack(1'b0);
        strobe_wr();
        chk(bus_oe == 1'b0, "R5 no oe in write direction", bus_oe, 0);
        release_wr();
        chk(pops == p0, "R5 write direction ignored", pops - p0, 0);
        @(negedge clk) rd_n = 1'b1;
        wait_clk(4);
        strobe_rd();
        release_rd();
        chk(pops == p0, "R5 rd edge ignored", pops - p0, 0);
        strobe_wr();
        chk(bus_dout == 8'hB1, "R5 byte B1", bus_dout, 8'hB1);
        chk(bus_oe == 1'b1, "R7 oe dir mode", bus_oe, 1);
        release_wr();
        strobe_wr();
        chk(bus_dout == 8'hB2, "R5 byte B2", bus_dout, 8'hB2);
        release_wr();
        chk(dma_req_n == 1'b0, "R6 one message left", dma_req_n, 0);
        strobe_wr(); release_wr();
        strobe_wr();
        chk(bus_dout == 8'hC2, "R5 byte C2", bus_dout, 8'hC2);
        release_wr();
        chk(pops == p0 + 4, "R5 four pops", pops - p0, 4);
        chk(dma_req_n == 1'b1, "R6 drained", dma_req_n, 1);
        set_ack(1'b1);
        dir_mode = 1'b0;
    endtask

    task automatic t_irq();
        int p0;
        @(negedge clk) req_en = 1'b0;
        put_byte(8'hD1, 1'b1);
        pulse_done();
        chk(irq_n == 1'b0, "R9 irq on disabled completion", irq_n, 0);
        chk(dma_req_n == 1'b1, "R2 no req when disabled", dma_req_n, 1);
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        wait_clk(2);
        chk(irq_n == 1'b1, "R9 irq cleared", irq_n, 1);
        @(negedge clk) req_en = 1'b1;
        wait_clk(2);
        chk(dma_req_n == 1'b0, "R2 req after enable", dma_req_n, 0);
        p0 = pops;
        set_ack(1'b0);
        strobe_rd();
        chk(bus_dout == 8'hD1, "R4 byte D1", bus_dout, 8'hD1);
        release_rd();
        chk(pops == p0 + 1, "R6 single pop", pops - p0, 1);
        chk(dma_req_n == 1'b1, "R6 released", dma_req_n, 1);
        chk(irq_n == 1'b1, "R9 no irq when enabled", irq_n, 1);
        set_ack(1'b1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'h00;
            lastf[i] = 1'b0;
        end
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_rd_mode();
        t_dir_mode();
        t_irq();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule